// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block selects the one interrupt cause that a 16550-style serial port reports to software, forms the identification byte for it and drives the interrupt request line. It takes the enable register contents, the receiver error and data-ready status, the receive FIFO fill count and trigger level, a character-timeout flag, the holding-register-empty status and the modem status change bits. Out of these it picks the most urgent enabled cause on every cycle.

The block owns two pieces of state. The first is the 4-bit enable register. The second is the holding-empty pending flag. The transmitter sets the pending flag when the holding register empties. A load of the holding register clears it, and so does a read of the identification register while that register shows the holding-empty code. Software can also re-arm the flag: toggling the holding-empty enable resamples the holding-empty level. Data FIFOs, the shifter and baud generation sit outside this block.

The identification byte and the interrupt line are combinational from the registered state and the current inputs. A read strobe samples the byte shown in the same cycle, and its side effect takes hold at the next clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the pending flag is clear, the identification low nibble is 0x1 and `irq` is 0.
- R2: `irq` is 1 exactly when the identification low nibble differs from 0x1 (no cause).
- R3: Enable bit 2 together with any bit of `lsr_err` gives code 0x6, which outranks every other cause.
- R4: A pending character timeout gated by enable bit 0 gives code 0xC. It ranks below the line-error cause and above received data.
- R5: Received-data code 0x4 needs enable bit 0 and `data_ready`. With `fifo_en` high it also needs `rx_count >= rx_trigger`. With `fifo_en` low, `data_ready` alone is enough.
- R6: Holding-empty code 0x2 needs enable bit 1 and the pending flag, and it ranks below received data.
- R7: Modem-status code 0x0 needs enable bit 3 and any bit of `msr_delta`, and it ranks lowest.
- R8: A read strobe in a cycle that shows code 0x2 clears the pending flag at the next edge. A read that shows any other code leaves the flag alone.
- R9: An enable write that changes bit 1 loads the pending flag with (new bit 1 AND `thr_empty`). A write that leaves bit 1 unchanged does not touch the flag. This rule beats every other update in the same cycle.
- R10: An enable write stores only `ier_wdata[3:0]`, visible on `ier_q` after the edge.
- R11: Identification bits 7:6 are 11 when `fifo_en` is high and 00 otherwise. Bits 5:4 are 0.
- R12: Without an R9 write, `thr_load` clears the pending flag. Otherwise `thr_empty_evt` sets it, and that set wins over an R8 read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode is on |
| lsr_err | input | 4 | Break, framing, parity, overrun status |
| data_ready | input | 1 | Receive data is available |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| timeout_pend | input | 1 | Character timeout is pending |
| thr_empty | input | 1 | Holding register empty level |
| thr_empty_evt | input | 1 | Pulse: holding register just emptied |
| thr_load | input | 1 | Pulse: holding register written |
| msr_delta | input | 4 | Modem status change bits |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| ier_q | output | 4 | Enable register contents |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that the line-error cause always wins, that `irq` tracks the no-cause code, and that the enable register stores the written nibble. They also check that an enable toggle, a holding-register load or an identification read leaves the pending flag in the required state on the next edge. Only the bench scenarios can show the full ranking as causes drop away one by one, the FIFO trigger threshold on both sides of equality, and a read that must not clear the flag while a higher cause hides the holding-empty code. The same holds for the set-versus-read tie and for the re-arm through an enable toggle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 5;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // index 0 = most urgent
  function automatic irq_id_e code_of(input int unsigned idx);
    case (idx)
      0:       code_of = ID_LINE;
      1:       code_of = ID_TIMEOUT;
      2:       code_of = ID_RXDATA;
      3:       code_of = ID_THRE;
      default: code_of = ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [3:0] ier_q,
  output logic       thri_toggle,
  output logic       thri_new
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= 4'h0;
    else if (wr) ier_q <= wdata[3:0];
  end

  assign thri_new    = wdata[1];
  assign thri_toggle = wr && (wdata[1] != ier_q[1]);

  // R10
  ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ier_q == $past(wdata[3:0]));
endmodule

// File: rtl/uart_thre_pending.sv
module uart_thre_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic thri_toggle,
  input  logic thri_new,
  input  logic thr_empty,
  input  logic thr_load,
  input  logic thr_empty_evt,
  input  logic rd_shows_thre,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (thri_toggle)      pend <= thri_new & thr_empty;
    else if (thr_load)         pend <= 1'b0;
    else if (thr_empty_evt)    pend <= 1'b1;
    else if (rd_shows_thre)    pend <= 1'b0;
  end

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thri_toggle |=> pend == $past(thri_new && thr_empty));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_shows_thre && !thri_toggle && !thr_empty_evt) |=> !pend);
  // R12
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_load && !thri_toggle) |=> !pend);
endmodule

// File: rtl/uart_irq_qualifier.sv
module uart_irq_qualifier
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [3:0]       ier_q,
  input  logic             fifo_en,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             timeout_pend,
  input  logic             thre_pend,
  input  logic [3:0]       msr_delta,
  output logic [NUM_SRC-1:0] active
);
  logic level_met;
  assign level_met = !fifo_en || (rx_count >= rx_trigger);

  assign active[0] = ier_q[2] && (|lsr_err);
  assign active[1] = ier_q[0] && timeout_pend;
  assign active[2] = ier_q[0] && data_ready && level_met;
  assign active[3] = ier_q[1] && thre_pend;
  assign active[4] = ier_q[3] && (|msr_delta);
endmodule

// File: rtl/uart_irq_priority.sv
module uart_irq_priority
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] active,
  output irq_id_e            code
);
  always_comb begin
    code = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) code = code_of(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             timeout_pend,
  input  logic             thr_empty,
  input  logic             thr_empty_evt,
  input  logic             thr_load,
  input  logic [3:0]       msr_delta,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iir_rd,
  output logic [3:0]       ier_q,
  output logic [7:0]       iir,
  output logic             irq
);
  logic               thri_toggle, thri_new, thre_pend;
  logic [NUM_SRC-1:0] active;
  irq_id_e            code;

  uart_irq_enable_reg u_ier (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .ier_q(ier_q), .thri_toggle(thri_toggle), .thri_new(thri_new)
  );

  uart_thre_pending u_pend (
    .clk(clk), .rst_n(rst_n), .thri_toggle(thri_toggle), .thri_new(thri_new),
    .thr_empty(thr_empty), .thr_load(thr_load), .thr_empty_evt(thr_empty_evt),
    .rd_shows_thre(iir_rd && (code == ID_THRE)), .pend(thre_pend)
  );

  uart_irq_qualifier #(.CNT_W(CNT_W)) u_qual (
    .ier_q(ier_q), .fifo_en(fifo_en), .lsr_err(lsr_err),
    .data_ready(data_ready), .rx_count(rx_count), .rx_trigger(rx_trigger),
    .timeout_pend(timeout_pend), .thre_pend(thre_pend),
    .msr_delta(msr_delta), .active(active)
  );

  uart_irq_priority u_prio (.active(active), .code(code));

  assign iir = {{2{fifo_en}}, 2'b00, code};
  assign irq = (code != ID_NONE);

  // R2
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != 4'h1));
  // R3
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|lsr_err)) |-> iir[3:0] == 4'h6);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CW = 5;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, data_ready = 0, timeout_pend = 0;
  logic thr_empty = 0, thr_empty_evt = 0, thr_load = 0;
  logic ier_wr = 0, iir_rd = 0;
  logic [3:0] lsr_err = 0, msr_delta = 0;
  logic [CW-1:0] rx_count = 0, rx_trigger = 0;
  logic [7:0] ier_wdata = 0;
  logic [3:0] ier_q;
  logic [7:0] iir;
  logic irq;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [3:0] m_ier = 0;
  logic       m_pend = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lsr_err(lsr_err),
    .data_ready(data_ready), .rx_count(rx_count), .rx_trigger(rx_trigger),
    .timeout_pend(timeout_pend), .thr_empty(thr_empty),
    .thr_empty_evt(thr_empty_evt), .thr_load(thr_load),
    .msr_delta(msr_delta), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .ier_q(ier_q), .iir(iir), .irq(irq)
  );

  function automatic logic [3:0] model_code();
    if (m_ier[2] && lsr_err != 0) return 4'h6;
    if (m_ier[0] && timeout_pend) return 4'hC;
    if (m_ier[0] && data_ready && (!fifo_en || rx_count >= rx_trigger)) return 4'h4;
    if (m_ier[1] && m_pend) return 4'h2;
    if (m_ier[3] && msr_delta != 0) return 4'h0;
    return 4'h1;
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    c = model_code();
    if (!rst_n) begin
      m_ier = 0; m_pend = 0;
    end else begin
      if (ier_wr && ier_wdata[1] != m_ier[1]) m_pend = ier_wdata[1] & thr_empty;
      else if (thr_load) m_pend = 0;
      else if (thr_empty_evt) m_pend = 1;
      else if (iir_rd && c == 4'h2) m_pend = 0;
      if (ier_wr) m_ier = ier_wdata[3:0];
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [7:0] e_iir;
    #2;
    if (!done) begin
      e_iir = {fifo_en ? 2'b11 : 2'b00, 2'b00, model_code()};
      check({cur_req, " cyc"}, {3'b0, irq, ier_q, iir},
            {3'b0, (e_iir[3:0] != 4'h1), m_ier, e_iir});
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ier_wr = 0; iir_rd = 0; thr_empty_evt = 0; thr_load = 0;
    end
  endtask

  task automatic wr_ier(logic [7:0] v);
    @(negedge clk);
    ier_wr = 1; ier_wdata = v; iir_rd = 0; thr_empty_evt = 0; thr_load = 0;
    step();
  endtask

  task automatic sample(string req, logic [7:0] exp_iir);
    #3 check(req, {7'b0, irq, iir}, {7'b0, (exp_iir[3:0] != 4'h1), exp_iir});
  endtask

  initial begin
    #10000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    #3 check("R1", {4'b0, ier_q, iir}, {4'b0, 4'h0, 8'h01});
    rst_n = 1;
    step(2);
    sample("R1", 8'h01);

    cur_req = "R10";
    wr_ier(8'hFF);
    #3 check("R10", {12'b0, ier_q}, 16'h000F);
    wr_ier(8'h00);

    cur_req = "R3";
    wr_ier(8'h05); lsr_err = 4'b0010; timeout_pend = 1;
    sample("R3", 8'h06);
    step(); lsr_err = 0;
    cur_req = "R4";
    data_ready = 1;
    sample("R4", 8'h0C);
    step(); timeout_pend = 0; data_ready = 0;

    cur_req = "R5";
    fifo_en = 1; data_ready = 1; rx_trigger = 4; rx_count = 3;
    sample("R5", 8'hC1);
    step(); rx_count = 4;
    sample("R5", 8'hC4);
    step(); fifo_en = 0; rx_count = 0;
    sample("R11", 8'h04);
    step(); data_ready = 0;
    wr_ier(8'h00);

    cur_req = "R9";
    thr_empty = 0; wr_ier(8'h02);
    sample("R9", 8'h01);
    cur_req = "R12";
    @(negedge clk); thr_empty_evt = 1; step();
    sample("R12", 8'h02);
    @(negedge clk); thr_load = 1; step();
    sample("R12", 8'h01);

    cur_req = "R8";
    @(negedge clk); thr_empty_evt = 1; step();
    sample("R6", 8'h02);
    @(negedge clk); iir_rd = 1; step();
    sample("R8", 8'h01);
    // read hidden by a higher cause must not clear
    wr_ier(8'h03);
    @(negedge clk); thr_empty_evt = 1; step();
    data_ready = 1;
    @(negedge clk); iir_rd = 1; step();
    data_ready = 0;
    sample("R8", 8'h02);
    // set and read in the same cycle: set wins
    @(negedge clk); iir_rd = 1; thr_empty_evt = 1; step();
    sample("R12", 8'h02);

    cur_req = "R9";
    @(negedge clk); iir_rd = 1; step();
    thr_empty = 1;
    wr_ier(8'h01); wr_ier(8'h03);
    sample("R9", 8'h02);
    @(negedge clk); iir_rd = 1; step();
    wr_ier(8'h03);
    sample("R9", 8'h01);

    cur_req = "R7";
    wr_ier(8'h08); msr_delta = 4'b0100;
    sample("R7", 8'h00);
    step();

    cur_req = "R6";
    wr_ier(8'h0F);
    lsr_err = 4'b1000; timeout_pend = 1; data_ready = 1;
    @(negedge clk); thr_empty_evt = 1; step();
    sample("R3", 8'h06);
    step(); lsr_err = 0;            sample("R4", 8'h0C);
    step(); timeout_pend = 0;       sample("R5", 8'h04);
    step(); data_ready = 0;         sample("R6", 8'h02);
    @(negedge clk); thr_load = 1; step();
    sample("R7", 8'h00);
    step(); msr_delta = 0;
    cur_req = "R11"; fifo_en = 1;
    sample("R11", 8'hC1);
    step(); fifo_en = 0;
    cur_req = "R2";
    sample("R2", 8'h01);
    step(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule